// File: doc/BRIEF.md
# Tagged Pixel Word Formatter

This block takes digitised pixel samples from many readout ports and turns them into a stream of fixed 21-bit words for a serial data link. Samples arrive through a valid/ready handshake that carries the sample value, the number of the port it came from, and a start-of-frame marker. Words leave through a second valid/ready handshake, at most one per clock cycle.

The block has two modes. In tagged mode each word carries one pixel, and the port number sits above the data. In packed mode the port tag is dropped. Three 14-bit pixels then fill exactly two words, so the link carries 1.5 pixels per word. A flush request pushes out a half-built group, with the spare bits set to zero and a last-word flag raised. The mode select input is sampled only at a group boundary: on a sample flagged start-of-frame, or on a flush.

The packing sequencer has three enumerated states:
- `PH_A`: awaiting the first pixel of a group.
- `PH_B`: the first pixel is held.
- `PH_C`: the first word has gone out and the low half of the second pixel is held.

The transitions are:
- A packed accept moves `PH_A`→`PH_B`, `PH_B`→`PH_C` and `PH_C`→`PH_A`.
- A tagged accept stays in `PH_A`.
- A start-of-frame sample is handled as if the sequencer were in `PH_A`.
- A flush returns to `PH_A` from any state.

The output is a single register stage. The input is ready only when that register is empty or is being drained in the same cycle.

Top module: `pixel_link_formatter`

## Requirements
- R1: After reset no word is presented (`out_valid`=0). In tagged mode every accepted sample yields one word: `out_word[20:16]` is the port number and `out_word[15:0]` is the sample. The word is presented in the cycle after acceptance.
- R2: In packed mode only `in_data[13:0]` is used and bits above it are ignored. For pixels p0, p1, p2, word 0 is {p0[13:0], p1[13:7]} and word 1 is {p1[6:0], p2[13:0]}, with the leftmost field in the most significant bits.
- R3: In packed mode the first pixel of a group produces no word. The second and third pixels each produce one word.
- R4: While `out_valid`=1 and `out_ready`=0, the word and flag hold still and `in_ready` is 0. Every expected word appears exactly once and in order, with none dropped and none repeated.
- R5: A sample with `in_sof`=1 starts a new group with itself as the first pixel. Any incomplete group is discarded without output.
- R6: A flush (`flush_req` accepted, never in the same cycle as `in_valid`) with one pixel pending emits {p0[13:0], 7'b0} with `out_last`=1.
- R7: A flush with two pixels pending emits {p1[6:0], 14'b0} with `out_last`=1.
- R8: A flush with no pixel pending, or in tagged mode, emits no word.
- R9: The mode after reset is tagged. `mode_sel` (1 = packed) takes effect only on a start-of-frame sample or on a flush, and is ignored at all other times.
- R10: `out_last` is 0 on every word that is not produced by a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Requested mode, 1 = packed, sampled at group boundaries |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample or flush can be taken this cycle |
| in_data | input | 16 | Sample value |
| in_port | input | 5 | Readout port number of the sample |
| in_sof | input | 1 | Sample is the first of a frame |
| flush_req | input | 1 | Force out a partial packed group |
| out_valid | output | 1 | Link word present |
| out_ready | input | 1 | Link takes the word |
| out_word | output | 21 | Link word |
| out_last | output | 1 | Word closes a flushed partial group |

## Verification
The bench sweeps all 32 port numbers in tagged mode. It then drives packed groups whose values keep the bits above bit 13 set. A design that placed the 7-bit split at the wrong position, or let the upper sample bits leak into packed words, would corrupt every second word. Flushes are issued with zero, one and two pixels pending, and start-of-frame is inserted mid-group. A design that kept stale half-pixels, or emitted an empty word on a boundary flush, shows up as a mismatched or unexpected word. A repeating stall pattern on `out_ready` exposes any word lost or doubled under backpressure. A `mode_sel` toggle inside a frame catches a design that switches mode at the wrong time.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } pack_phase_e;
endpackage

// File: rtl/pixfmt_pack_fsm.sv
module pixfmt_pack_fsm
    import pixfmt_pkg::*;
#(
    parameter int WORD_W = 21,
    parameter int PORT_W = 5,
    localparam int DATA_W = WORD_W - PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              flush_fire,
    input  logic              mode_sel,
    input  logic              in_sof,
    input  logic [DATA_W-1:0] in_data,
    input  logic [PORT_W-1:0] in_port,
    output logic              emit_valid,
    output logic [WORD_W-1:0] emit_word,
    output logic              emit_last
);
    localparam int PACK_W  = (2 * WORD_W) / 3;
    localparam int SPLIT_W = WORD_W - PACK_W;

    pack_phase_e          state_q, state_d;
    logic                 mode_q, mode_d;
    logic [PACK_W-1:0]    hold_hi_q, hold_hi_d;
    logic [SPLIT_W-1:0]   hold_lo_q, hold_lo_d;

    pack_phase_e          cur_ph;
    logic                 eff_mode;
    logic [PACK_W-1:0]    pix;

    assign cur_ph   = in_sof ? PH_A : state_q;
    assign eff_mode = in_sof ? mode_sel : mode_q;
    assign pix      = in_data[PACK_W-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PH_A;
            mode_q    <= 1'b0;
            hold_hi_q <= '0;
            hold_lo_q <= '0;
        end else begin
            state_q   <= state_d;
            mode_q    <= mode_d;
            hold_hi_q <= hold_hi_d;
            hold_lo_q <= hold_lo_d;
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        hold_hi_d = hold_hi_q;
        hold_lo_d = hold_lo_q;
        if (flush_fire) begin
            state_d = PH_A;
            mode_d  = mode_sel;
        end else if (accept) begin
            mode_d = eff_mode;
            if (!eff_mode) begin
                state_d = PH_A;
            end else begin
                unique case (cur_ph)
                    PH_A: begin
                        hold_hi_d = pix;
                        state_d   = PH_B;
                    end
                    PH_B: begin
                        hold_lo_d = pix[SPLIT_W-1:0];
                        state_d   = PH_C;
                    end
                    default: state_d = PH_A;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        emit_valid = 1'b0;
        emit_word  = '0;
        emit_last  = 1'b0;
        if (flush_fire) begin
            unique case (state_q)
                PH_B: begin
                    emit_valid = 1'b1;
                    emit_word  = {hold_hi_q, {(WORD_W-PACK_W){1'b0}}};
                    emit_last  = 1'b1;
                end
                PH_C: begin
                    emit_valid = 1'b1;
                    emit_word  = {hold_lo_q, {(WORD_W-SPLIT_W){1'b0}}};
                    emit_last  = 1'b1;
                end
                default: emit_valid = 1'b0;
            endcase
        end else if (accept) begin
            if (!eff_mode) begin
                emit_valid = 1'b1;
                emit_word  = {in_port, in_data};
            end else begin
                unique case (cur_ph)
                    PH_B: begin
                        emit_valid = 1'b1;
                        emit_word  = {hold_hi_q, pix[PACK_W-1:SPLIT_W]};
                    end
                    PH_C: begin
                        emit_valid = 1'b1;
                        emit_word  = {hold_lo_q, pix};
                    end
                    default: emit_valid = 1'b0;
                endcase
            end
        end
    end

    // a half-built group exists only while packing
    p_partial_packed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_A) |-> mode_q);

    // the third pixel closes the group
    p_group_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_sof && state_q == PH_C) |=> (state_q == PH_A));

    // the mode moves only on start-of-frame or flush
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_fire && !(accept && in_sof)) |=> $stable(mode_q));
endmodule

// File: rtl/pixfmt_out_stage.sv
module pixfmt_out_stage #(
    parameter int WORD_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_valid,
    input  logic [WORD_W-1:0] emit_word,
    input  logic              emit_last,
    output logic              up_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              out_last
);
    logic              valid_q;
    logic [WORD_W-1:0] word_q;
    logic              last_q;

    assign up_ready  = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_word  = word_q;
    assign out_last  = last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            word_q  <= '0;
            last_q  <= 1'b0;
        end else if (up_ready) begin
            valid_q <= emit_valid;
            word_q  <= emit_word;
            last_q  <= emit_last;
        end
    end

    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));
endmodule

// File: rtl/pixel_link_formatter.sv
module pixel_link_formatter #(
    parameter int WORD_W = 21,
    parameter int PORT_W = 5,
    localparam int DATA_W = WORD_W - PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [PORT_W-1:0] in_port,
    input  logic              in_sof,
    input  logic              flush_req,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              out_last
);
    logic              up_ready;
    logic              accept;
    logic              flush_fire;
    logic              emit_valid;
    logic [WORD_W-1:0] emit_word;
    logic              emit_last;

    assign in_ready   = up_ready;
    assign accept     = in_valid && up_ready;
    assign flush_fire = flush_req && up_ready;

    pixfmt_pack_fsm #(.WORD_W(WORD_W), .PORT_W(PORT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .flush_fire (flush_fire),
        .mode_sel   (mode_sel),
        .in_sof     (in_sof),
        .in_data    (in_data),
        .in_port    (in_port),
        .emit_valid (emit_valid),
        .emit_word  (emit_word),
        .emit_last  (emit_last)
    );

    pixfmt_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit_valid (emit_valid),
        .emit_word  (emit_word),
        .emit_last  (emit_last),
        .up_ready   (up_ready),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_word   (out_word),
        .out_last   (out_last)
    );

    // a flush never shares a cycle with a sample
    p_flush_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_req && in_valid));

    // after a flush either nothing or a closing word is presented
    p_flush_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fire |=> (!out_valid || out_last));

    // a stalled link blocks the input
    p_stall_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/sim_pixel_link_formatter.sv
module sim_pixel_link_formatter;
    localparam int CLK_P  = 10;
    localparam int WORD_W = 21;
    localparam int PORT_W = 5;
    localparam int DATA_W = WORD_W - PORT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_sel = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic [PORT_W-1:0] in_port = '0;
    logic              in_sof = 1'b0;
    logic              flush_req = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [WORD_W-1:0] out_word;
    logic              out_last;

    always #(CLK_P/2) clk = ~clk;

    pixel_link_formatter #(.WORD_W(WORD_W), .PORT_W(PORT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_port(in_port), .in_sof(in_sof), .flush_req(flush_req),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_last(out_last)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected stream
    logic [WORD_W-1:0] exp_w[$];
    logic              exp_l[$];
    string             exp_r[$];

    task automatic push(input logic [WORD_W-1:0] w, input logic l, input string r);
        exp_w.push_back(w);
        exp_l.push_back(l);
        exp_r.push_back(r);
    endtask

    // arithmetic reference of the requirements
    logic        mode_m = 1'b0;
    int          pend = 0;
    logic [13:0] a_m = '0;
    logic [6:0]  b_m = '0;

    // link backpressure pattern
    logic stall_on = 1'b0;
    int   cyc = 0;
    always begin
        @(posedge clk);
        #1;
        cyc = cyc + 1;
        out_ready = !stall_on || (((cyc % 5) != 2) && ((cyc % 7) != 3));
    end

    // monitor away from the active edge
    logic              prev_stall = 1'b0;
    logic [WORD_W-1:0] prev_word = '0;
    logic              prev_last = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(out_valid && out_word == prev_word && out_last == prev_last,
                      "R4", "word changed under stall", 32'(out_word), 32'(prev_word));
            prev_stall = out_valid && !out_ready;
            prev_word  = out_word;
            prev_last  = out_last;
            if (out_valid && out_ready) begin
                if (exp_w.size() == 0) begin
                    check(1'b0, "R4", "unexpected word", 32'(out_word), 32'h0);
                end else begin
                    logic [WORD_W-1:0] ew;
                    logic              el;
                    string             er;
                    ew = exp_w.pop_front();
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    check(out_word == ew, er, "word", 32'(out_word), 32'(ew));
                    check(out_last == el, "R10", "last flag", 32'(out_last), 32'(el));
                end
            end
        end
    end

    task automatic send(input logic [DATA_W-1:0] d, input logic [PORT_W-1:0] p,
                        input logic sof, input string req);
        if (sof) begin
            mode_m = mode_sel;
            pend = 0;
        end
        if (!mode_m) begin
            push({p, d}, 1'b0, req);
        end else begin
            case (pend)
                0: begin a_m = d[13:0]; pend = 1; end
                1: begin push({a_m, d[13:7]}, 1'b0, req); b_m = d[6:0]; pend = 2; end
                default: begin push({b_m, d[13:0]}, 1'b0, req); pend = 0; end
            endcase
        end
        in_valid = 1'b1; in_data = d; in_port = p; in_sof = sof;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic flush(input string req);
        if (pend == 1) push({a_m, 7'b0}, 1'b1, req);
        else if (pend == 2) push({b_m, 14'b0}, 1'b1, req);
        pend = 0;
        mode_m = mode_sel;
        flush_req = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        flush_req = 1'b0;
    endtask

    task automatic drain();
        while (exp_w.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R1", "valid after reset", 32'(out_valid), 32'h0);
        check(in_ready, "R4", "ready after reset", 32'(in_ready), 32'h1);
        @(posedge clk);
        #1;

        // R1: tagged sweep over every port
        for (int p = 0; p < 32; p++)
            send(16'((p * 4099 + 123) & 16'hFFFF), 5'(p), (p == 0), "R1");
        drain();

        // R9: mode request mid-frame is ignored
        mode_sel = 1'b1;
        for (int i = 0; i < 4; i++)
            send(16'(i * 911 + 7), 5'(i + 3), 1'b0, "R9");
        drain();
        stall_on = 1'b1;

        // R3: a lone first pixel of a group gives no word
        send(16'hC123, 5'd1, 1'b1, "R3");
        repeat (4) begin
            @(negedge clk);
            check(!out_valid, "R3", "word from first pixel", 32'(out_valid), 32'h0);
        end
        @(posedge clk);
        #1;

        // R2: ten full groups, upper sample bits set
        for (int i = 0; i < 30; i++)
            send(16'((i * 2731 + 77) | 16'hC000), 5'(i), (i == 0), "R2");
        drain();

        // R5: start-of-frame after one and after two pending pixels
        send(16'h1111, 5'd2, 1'b0, "R5");
        send(16'h2ABC, 5'd2, 1'b1, "R5");
        send(16'h3DEF, 5'd2, 1'b0, "R5");
        send(16'h0F0F, 5'd2, 1'b1, "R5");
        send(16'h1234, 5'd2, 1'b0, "R5");
        send(16'h3FFF, 5'd2, 1'b0, "R5");
        drain();

        // R6: flush with one pixel pending
        send(16'h2A5A, 5'd0, 1'b0, "R6");
        flush("R6");
        drain();

        // R7: flush with two pending
        send(16'h1357, 5'd0, 1'b0, "R7");
        send(16'h2468, 5'd0, 1'b0, "R7");
        flush("R7");
        drain();

        // R8: flush on a boundary emits nothing
        flush("R8");
        drain();

        // R9: packed request stays while mode_sel drops, until flush
        mode_sel = 1'b0;
        send(16'h0ACE, 5'd9, 1'b0, "R9");
        send(16'h3BDF, 5'd9, 1'b0, "R9");
        send(16'h1A2B, 5'd9, 1'b0, "R9");
        send(16'h0001, 5'd9, 1'b0, "R9");
        flush("R9");
        for (int i = 0; i < 5; i++)
            send(16'(i * 3001 + 9), 5'(31 - i), 1'b0, "R9");
        drain();

        // R8: flush in tagged mode emits nothing
        flush("R8");
        drain();

        check(exp_w.size() == 0, "R4", "missing words", 32'(exp_w.size()), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule